// File: doc/BRIEF.md
# Serial Nibble Register Access Master

This block runs register transfers to a small clock-calendar peripheral over three wires: a serial clock, one bidirectional data line and a chip enable. A request carries a direction flag, a 4-bit register address and, for a write, a 4-bit value. The block builds a 16-clock frame for it. The frame starts with a 4-bit control header and the address. A read then turns the data line around and clocks in eight bits, of which only the last four are kept. A write sends a second control header and the data nibble instead.

Chip enable is not driven by this block. Software raises it around a group of transfers, and the block only looks at it to refuse requests made while it is low. The serial clock comes from the system clock through a half-period divider. Output bits change while the serial clock is low, and the input bit is sampled on its rising edge.

Top module: `nib_ser_master`

## Requirements
- R1: The first four serial clocks of every frame carry, in order, 1, the direction bit (1 for read, 0 for write), 1, 0.
- R2: Clocks 5 to 8 carry the register address, most significant bit first.
- R3: In a read, `sdo_oe_o` is low from clock 9 through 16. The bits on clocks 9 to 12 are discarded, the bits on clocks 13 to 16 form the result MSB first, and the result appears on `rdata_o`.
- R4: In a write, clocks 9 to 12 carry 1, 0, 0, 1, and `sdo_oe_o` stays high for all 16 clocks.
- R5: In a write, clocks 13 to 16 carry the data nibble, most significant bit first.
- R6: Each accepted frame has exactly 16 rising edges of `sclk_o`, and `sclk_o` is low between frames.
- R7: Each serial clock half-period lasts `DIV_HALF` system cycles. `sdo_o` and `sdo_oe_o` change only while `sclk_o` is low.
- R8: `req_ready_o` is high only while no frame is running. A request is taken when `req_valid_i` and `req_ready_o` are both high.
- R9: `done_o` pulses for one cycle at the falling edge that closes a frame. `rdata_o` is updated then, and set to 0 after a write.
- R10: A request taken while `ce_i` is low starts no frame. It raises `err_o` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Software-held chip enable level |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 4 | Register address |
| req_wdata_i | input | 4 | Write data |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| rdata_o | output | 4 | Captured read nibble |
| err_o | output | 1 | One-cycle refusal pulse |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Data line drive enable |
| sdi_i | input | 1 | Serial data in |

## Verification
Reads are driven with line patterns whose four turnaround bits differ from the data bits: all ones before 0101, 0011 before 1010, and all zeros before 1111. A result built from the wrong window of bits therefore shows up. Writes use address/data pairs with distinct bit patterns, so that a swapped header bit or a reversed nibble stands out. Back-to-back reads and writes inside one chip-enable window check that state does not carry over between frames. A refused request followed by a good one separates refusal from a stuck engine.

// File: rtl/nib_ser_pkg.sv
package nib_ser_pkg;
  localparam int NIB_W   = 4;
  localparam int FRAME_W = 4 * NIB_W;
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam logic [NIB_W-1:0] HDR_RD   = 4'b1110;
  localparam logic [NIB_W-1:0] HDR_WR   = 4'b1010;
  localparam logic [NIB_W-1:0] HDR_WDAT = 4'b1001;
endpackage

// File: rtl/nsm_div.sv
module nsm_div #(
  parameter int HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nsm_frame.sv
module nsm_frame
  import nib_ser_pkg::*;
(
  input  logic              write_i,
  input  logic [NIB_W-1:0]  addr_i,
  input  logic [NIB_W-1:0]  wdata_i,
  output logic [FRAME_W-1:0] bits_o,
  output logic [FRAME_W-1:0] oe_o
);
  always_comb begin
    if (write_i) begin
      bits_o = {HDR_WR, addr_i, HDR_WDAT, wdata_i};
      oe_o   = '1;
    end else begin
      bits_o = {HDR_RD, addr_i, {(2*NIB_W){1'b0}}};
      oe_o   = {{(2*NIB_W){1'b1}}, {(2*NIB_W){1'b0}}};
    end
  end
endmodule

// File: rtl/nib_ser_master.sv
module nib_ser_master
  import nib_ser_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [NIB_W-1:0] req_addr_i,
  input  logic [NIB_W-1:0] req_wdata_i,
  output logic             done_o,
  output logic [NIB_W-1:0] rdata_o,
  output logic             err_o,
  output logic             sclk_o,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  input  logic             sdi_i
);
  logic               busy_q, phase_q, done_q, err_q, tick;
  logic [BIT_W-1:0]   bit_q;
  logic [FRAME_W-1:0] tx_q, oe_q, frm_bits, frm_oe;
  logic [NIB_W-1:0]   rx_q, rdata_q;

  nsm_div #(.HALF(DIV_HALF)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_q),
    .tick_o(tick)
  );

  nsm_frame u_frame (
    .write_i(req_write_i),
    .addr_i (req_addr_i),
    .wdata_i(req_wdata_i),
    .bits_o (frm_bits),
    .oe_o   (frm_oe)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      bit_q   <= '0;
      tx_q    <= '0;
      oe_q    <= '0;
      rx_q    <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!busy_q) begin
        if (req_valid_i) begin
          if (!ce_i) err_q <= 1'b1;
          else begin
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
            bit_q   <= '0;
            tx_q    <= frm_bits;
            oe_q    <= frm_oe;
            rx_q    <= '0;
          end
        end
      end else if (tick) begin
        if (!phase_q) begin
          phase_q <= 1'b1;
          // line released: sample on rising edge, keep the last nibble
          if (!oe_q[FRAME_W-1]) rx_q <= {rx_q[NIB_W-2:0], sdi_i};
        end else begin
          phase_q <= 1'b0;
          if (bit_q == BIT_W'(FRAME_W - 1)) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            rdata_q <= rx_q;
            tx_q    <= '0;
            oe_q    <= '0;
          end else begin
            bit_q <= bit_q + 1'b1;
            tx_q  <= tx_q << 1;
            oe_q  <= oe_q << 1;
          end
        end
      end
    end
  end

  assign req_ready_o = !busy_q;
  assign sclk_o      = busy_q && phase_q;
  assign sdo_o       = tx_q[FRAME_W-1];
  assign sdo_oe_o    = busy_q && oe_q[FRAME_W-1];
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/nib_ser_master_chk.sv
module nib_ser_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic done_o,
  input logic err_o,
  input logic sclk_o,
  input logic sdo_o,
  input logic sdo_oe_o
);
  AST_IDLE_SCLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !sclk_o); // R6
  AST_SDO_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdo_o)); // R7
  AST_OE_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdo_oe_o)); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o); // R8
  AST_ERR_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (req_ready_o && !sdo_oe_o)); // R10
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R10
endmodule

bind nib_ser_master nib_ser_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .sclk_o     (sclk_o),
  .sdo_o      (sdo_o),
  .sdo_oe_o   (sdo_oe_o)
);

// File: tb/nib_ser_master_test.sv
module nib_ser_master_test;
  localparam int HALF = 2;

  typedef struct packed {
    logic [15:0] bits;
    logic [15:0] oe;
    logic [3:0]  rdata;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, valid = 1'b0, wr = 1'b0, sdi = 1'b0;
  logic [3:0] addr = '0, wdata = '0;
  logic ready, done, err, sclk, sdo, oe;
  logic [3:0] rdata;

  int n_run = 0, n_fail = 0, n_rise = 0, hi_cnt = 0, n_done = 0;
  logic [15:0] cap_b, cap_o, sdi_pat;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  nib_ser_master #(.DIV_HALF(HALF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce),
    .req_valid_i(valid), .req_ready_o(ready), .req_write_i(wr),
    .req_addr_i(addr), .req_wdata_i(wdata),
    .done_o(done), .rdata_o(rdata), .err_o(err),
    .sclk_o(sclk), .sdo_o(sdo), .sdo_oe_o(oe), .sdi_i(sdi)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // slave model: record line on each rise, present next input bit
  always @(posedge sclk) begin
    if (n_rise < 16) begin
      cap_b[15-n_rise] = sdo;
      cap_o[15-n_rise] = oe;
    end
    n_rise++;
    if (n_rise < 16) sdi = sdi_pat[15-n_rise];
  end

  // monitor: high-phase counting and scoreboard compare
  always @(negedge clk) begin
    if (sclk) hi_cnt++;
    if (done) begin
      exp_t e;
      n_done++;
      if (exp_q.size() == 0) begin
        check("R9 unexpected done", 32'd1, 32'd0);
      end else begin
        e = exp_q.pop_front();
        check("R1 header", {28'd0, cap_b[15:12]}, {28'd0, e.bits[15:12]});
        check("R2 address", {28'd0, cap_b[11:8]}, {28'd0, e.bits[11:8]});
        check("R3/R4 line direction", {16'd0, cap_o}, {16'd0, e.oe});
        if (e.oe[0]) begin
          check("R4 second header", {28'd0, cap_b[7:4]}, {28'd0, e.bits[7:4]});
          check("R5 write data", {28'd0, cap_b[3:0]}, {28'd0, e.bits[3:0]});
        end
        check("R3/R9 rdata", {28'd0, rdata}, {28'd0, e.rdata});
        check("R6 rise count", n_rise, 32'd16);
        check("R6 sclk low at end", {31'd0, sclk}, 32'd0);
        check("R7 high time", hi_cnt, 32'(16 * HALF));
      end
    end
  end

  task automatic xfer(input logic w, input logic [3:0] a, input logic [3:0] d, input logic [15:0] pat);
    exp_t e;
    e.bits  = w ? {4'b1010, a, 4'b1001, d} : {4'b1110, a, 8'h00};
    e.oe    = w ? 16'hFFFF : 16'hFF00;
    e.rdata = w ? 4'h0 : pat[3:0];
    exp_q.push_back(e);
    sdi_pat = pat;
    sdi     = pat[15];
    n_rise  = 0;
    hi_cnt  = 0;
    @(negedge clk);
    valid = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0;
    check("R8 ready low in frame", {31'd0, ready}, 32'd0);
    while (exp_q.size() != 0) @(negedge clk);
    check("R8 ready after frame", {31'd0, ready}, 32'd1);
    check("R9 done one cycle", {31'd0, done}, 32'd0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset ready", {31'd0, ready}, 32'd1);
    check("R6 reset sclk", {31'd0, sclk}, 32'd0);
    check("R3 reset oe", {31'd0, oe}, 32'd0);
    check("R9 reset done", {30'd0, done, err}, 32'd0);

    ce = 1'b1;
    xfer(1'b0, 4'hD, 4'h0, 16'h00F5);
    xfer(1'b0, 4'h2, 4'h0, 16'h003A);
    xfer(1'b1, 4'h5, 4'h9, 16'hFFFF);
    xfer(1'b1, 4'hA, 4'h6, 16'h0000);
    xfer(1'b0, 4'hF, 4'h0, 16'h0F0F);

    // R10: refusal while chip enable is low
    ce = 1'b0;
    d0 = n_done;
    n_rise = 0;
    @(negedge clk);
    valid = 1'b1; wr = 1'b1; addr = 4'h3; wdata = 4'hC;
    @(negedge clk);
    valid = 1'b0;
    check("R10 err pulse", {31'd0, err}, 32'd1);
    @(negedge clk);
    check("R10 err single cycle", {31'd0, err}, 32'd0);
    repeat (40) @(negedge clk);
    check("R10 no clocks", n_rise, 32'd0);
    check("R10 no done", n_done, d0);
    check("R10 still ready", {31'd0, ready}, 32'd1);

    ce = 1'b1;
    xfer(1'b1, 4'h3, 4'hC, 16'h0000);
    xfer(1'b0, 4'h8, 4'h0, 16'h0056);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule